// File: doc/BRIEF.md
# Comparator Edge Flag Status Register

This block is the digital status and control register for an analog comparator. It takes the comparator's output bit, which is already synchronized to the block clock. It records rising and falling transitions of that bit in two sticky flags, each with its own interrupt enable, and raises a single interrupt request when any enabled flag is set. An 8-bit register gives a bus master read and write access. The flags are cleared by writing 1 to them.

In normal operation the flags capture edges. When the stop-mode input is high, they follow the level of the output instead. Two further inputs, the comparator enable and the invert setting, decide what the output bit reads back as. While the comparator is disabled, the output bit holds the invert setting. Edge and level detection always act on the same effective value that the output bit reads back.

Top module: `cmp_edge_status`

## Requirements
- R1: After reset the flags and both interrupt enables are 0, and `irq_o` is low.
- R2: Read-data bits 7, 6 and 5 always read 0, and writes to them have no effect.
- R3: Bit 4 (rising interrupt enable) and bit 3 (falling interrupt enable) are read/write. A write with `reg_wr_i` high stores `reg_wdata_i[4:3]` into them.
- R4: In normal mode, the rising flag (bit 2) is set on the clock edge that first samples a 0-to-1 change of the effective output bit.
- R5: In normal mode, the falling flag (bit 1) is set on the clock edge that first samples a 1-to-0 change of the effective output bit.
- R6: A flag stays set until a write puts 1 in its bit position, which clears it. Writing 0 in that position leaves the flag unchanged.
- R7: If a clearing write and a new set condition for the same flag occur in the same cycle, the flag ends up set.
- R8: While `stop_mode_i` is high, the rising flag is set on every clock edge where the effective output is 1, and the falling flag on every edge where it is 0. A clearing write cannot clear a flag whose level condition holds.
- R9: `irq_o` is high exactly when (bit 2 and bit 4 are both 1) or (bit 1 and bit 3 are both 1).
- R10: Bit 0 reads `cmp_out_i` while `cmp_en_i` is 1 and reads `cmp_inv_i` while `cmp_en_i` is 0. Writes to bit 0 are ignored.
- R11: No edge is reported on the first clock edge after reset is released, whatever the output value is then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmp_out_i | input | 1 | Synchronized comparator output bit |
| cmp_en_i | input | 1 | Comparator enable |
| cmp_inv_i | input | 1 | Invert setting, read back as the output while disabled |
| stop_mode_i | input | 1 | High selects level capture of the flags |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench clears a flag in the same cycle that a new edge arrives on it. A design that lets the clear win would lose that event. It drives a high output bit through reset release, where a previous-value register that starts at 0 would report a rising edge that never happened. It toggles enable and invert while the comparator is disabled, so that edges must follow the read-back value rather than the raw input. It also writes 1 to a flag in stop mode while the flag's level condition holds, which a design that kept edge capture in stop mode would get wrong by clearing the flag.

// File: rtl/cmpsr_pkg.sv
package cmpsr_pkg;
  localparam int REG_W      = 8;
  localparam int BIT_OUT    = 0;
  localparam int BIT_FFALL  = 1;
  localparam int BIT_FRISE  = 2;
  localparam int BIT_EFALL  = 3;
  localparam int BIT_ERISE  = 4;
  localparam int NUM_FLAGS  = 2;
  localparam int IDX_RISE   = 0;
  localparam int IDX_FALL   = 1;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_pair_t;
endpackage

// File: rtl/cmpsr_rst_sync.sv
module cmpsr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cmpsr_edge_detect.sv
module cmpsr_edge_detect
  import cmpsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmp_out_i,
  input  logic       cmp_en_i,
  input  logic       cmp_inv_i,
  input  logic       stop_mode_i,
  output logic       eff_o,
  output edge_pair_t set_o
);
  logic       prev_q, prev_d;
  logic       primed_q, primed_d;
  edge_pair_t edges;

  // effective output: live value while enabled, invert setting otherwise
  always_comb begin
    eff_o = cmp_en_i ? cmp_out_i : cmp_inv_i;
  end

  always_comb begin
    prev_d   = eff_o;
    primed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= prev_d;
      primed_q <= primed_d;
    end
  end

  always_comb begin
    edges.rise = primed_q &  eff_o & ~prev_q;
    edges.fall = primed_q & ~eff_o &  prev_q;
    if (stop_mode_i) begin
      set_o.rise = eff_o;
      set_o.fall = ~eff_o;
    end else begin
      set_o = edges;
    end
  end

  // R11: an edge is only ever reported against a value sampled after reset
  assert_rise_real_R11: assert property (@(posedge clk) disable iff (!rst_n)
    edges.rise |-> ($past(eff_o) == 1'b0));
  assert_fall_real_R11: assert property (@(posedge clk) disable iff (!rst_n)
    edges.fall |-> ($past(eff_o) == 1'b1));
  // R8: in stop mode exactly one set condition is active
  assert_stop_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_mode_i |-> $onehot(set_o));
endmodule

// File: rtl/cmpsr_flag.sv
module cmpsr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  // set dominates a concurrent clear
  always_comb begin
    flag_d = set_i | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && flag_o) |=> flag_o);
endmodule

// File: rtl/cmpsr_ctrl_reg.sv
module cmpsr_ctrl_reg
  import cmpsr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_i,
  input  logic [NUM_FLAGS-1:0] wdata_i,
  output logic [NUM_FLAGS-1:0] en_o
);
  logic [NUM_FLAGS-1:0] en_q, en_d;

  always_comb begin
    en_d = en_q;
    if (wr_i) en_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  assign en_o = en_q;

  assert_en_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(en_o));
  assert_en_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (en_o == $past(wdata_i)));
endmodule

// File: rtl/cmp_edge_status.sv
module cmp_edge_status
  import cmpsr_pkg::*;
#(
  parameter int RST_SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_out_i,
  input  logic             cmp_en_i,
  input  logic             cmp_inv_i,
  input  logic             stop_mode_i,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             irq_o
);
  logic                 rst_int_n;
  logic                 eff;
  edge_pair_t           set_pair;
  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] clr_vec;
  logic [NUM_FLAGS-1:0] flag_vec;
  logic [NUM_FLAGS-1:0] ien_vec;
  logic [NUM_FLAGS-1:0] ien_wdata;
  logic                 unused_wbits;

  cmpsr_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  cmpsr_edge_detect u_edge (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .cmp_out_i   (cmp_out_i),
    .cmp_en_i    (cmp_en_i),
    .cmp_inv_i   (cmp_inv_i),
    .stop_mode_i (stop_mode_i),
    .eff_o       (eff),
    .set_o       (set_pair)
  );

  always_comb begin
    set_vec[IDX_RISE]   = set_pair.rise;
    set_vec[IDX_FALL]   = set_pair.fall;
    clr_vec[IDX_RISE]   = reg_wr_i & reg_wdata_i[BIT_FRISE];
    clr_vec[IDX_FALL]   = reg_wr_i & reg_wdata_i[BIT_FFALL];
    ien_wdata[IDX_RISE] = reg_wdata_i[BIT_ERISE];
    ien_wdata[IDX_FALL] = reg_wdata_i[BIT_EFALL];
  end

  assign unused_wbits = ^{reg_wdata_i[REG_W-1:BIT_ERISE+1], reg_wdata_i[BIT_OUT]};

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    cmpsr_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .set_i  (set_vec[g]),
      .clr_i  (clr_vec[g]),
      .flag_o (flag_vec[g])
    );
  end

  cmpsr_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_i    (reg_wr_i),
    .wdata_i (ien_wdata),
    .en_o    (ien_vec)
  );

  always_comb begin
    reg_rdata_o            = '0;
    reg_rdata_o[BIT_OUT]   = eff;
    reg_rdata_o[BIT_FFALL] = flag_vec[IDX_FALL];
    reg_rdata_o[BIT_FRISE] = flag_vec[IDX_RISE];
    reg_rdata_o[BIT_EFALL] = ien_vec[IDX_FALL];
    reg_rdata_o[BIT_ERISE] = ien_vec[IDX_RISE];
  end

  assign irq_o = |(flag_vec & ien_vec);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    reg_rdata_o[REG_W-1:BIT_ERISE+1] == '0);
  assert_out_disabled_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    !cmp_en_i |-> (reg_rdata_o[BIT_OUT] == cmp_inv_i));
  assert_irq_on_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((reg_rdata_o[BIT_ERISE] && reg_rdata_o[BIT_FRISE]) ||
     (reg_rdata_o[BIT_EFALL] && reg_rdata_o[BIT_FFALL])) |-> irq_o);
  assert_irq_off_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!(reg_rdata_o[BIT_ERISE] && reg_rdata_o[BIT_FRISE]) &&
     !(reg_rdata_o[BIT_EFALL] && reg_rdata_o[BIT_FFALL])) |-> !irq_o);
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_int_n |-> (!irq_o && reg_rdata_o[BIT_ERISE:BIT_FFALL] == '0));
endmodule

// File: tb/cmp_edge_status_tb_top.sv
module cmp_edge_status_tb_top;
  logic       clk;
  logic       rst_n;
  logic       cmp_out_i, cmp_en_i, cmp_inv_i, stop_mode_i;
  logic       reg_wr_i;
  logic [7:0] reg_wdata_i;
  logic [7:0] reg_rdata_o;
  logic       irq_o;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit done     = 0;

  cmp_edge_status dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmp_out_i   (cmp_out_i),
    .cmp_en_i    (cmp_en_i),
    .cmp_inv_i   (cmp_inv_i),
    .stop_mode_i (stop_mode_i),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {wr, wdata[7:0], cmp, en, inv, stop, exp_rdata[7:0], exp_irq}
  localparam int NV = 25;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b0, 8'h18, 1'b0}, // R3 R2
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h1D, 1'b1}, // R4
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h1D, 1'b1}, // R6 sticky
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h1E, 1'b1}, // R5
    {1'b1, 8'h18, 1'b0, 1'b1, 1'b0, 1'b0, 8'h1E, 1'b1}, // R6 write 0
    {1'b1, 8'h1C, 1'b0, 1'b1, 1'b0, 1'b0, 8'h1A, 1'b1}, // R6 clear rise
    {1'b1, 8'h1A, 1'b0, 1'b1, 1'b0, 1'b0, 8'h18, 1'b0}, // R6 clear fall
    {1'b1, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h05, 1'b0}, // R9 no enable
    {1'b1, 8'h10, 1'b1, 1'b1, 1'b0, 1'b0, 8'h15, 1'b1}, // R9
    {1'b1, 8'h14, 1'b0, 1'b1, 1'b0, 1'b0, 8'h12, 1'b0}, // R9
    {1'b1, 8'h0A, 1'b0, 1'b1, 1'b0, 1'b0, 8'h08, 1'b0}, // R6
    {1'b1, 8'h0A, 1'b1, 1'b1, 1'b0, 1'b0, 8'h0D, 1'b0}, // R4 R9
    {1'b1, 8'h0C, 1'b0, 1'b1, 1'b0, 1'b0, 8'h0A, 1'b1}, // R5 R9
    {1'b1, 8'h0A, 1'b1, 1'b1, 1'b0, 1'b0, 8'h0D, 1'b0}, // R4
    {1'b1, 8'h0C, 1'b0, 1'b1, 1'b0, 1'b0, 8'h0A, 1'b1}, // R5
    {1'b1, 8'h0C, 1'b1, 1'b1, 1'b0, 1'b0, 8'h0F, 1'b1}, // R7 set wins
    {1'b1, 8'h06, 1'b1, 1'b0, 1'b0, 1'b0, 8'h02, 1'b0}, // R10 R7
    {1'b1, 8'h02, 1'b0, 1'b0, 1'b1, 1'b0, 8'h05, 1'b0}, // R10
    {1'b1, 8'h04, 1'b0, 1'b0, 1'b1, 1'b0, 8'h01, 1'b0}, // R10 write ignored
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 8'h05, 1'b0}, // R8
    {1'b1, 8'h04, 1'b1, 1'b1, 1'b0, 1'b1, 8'h05, 1'b0}, // R8 level holds
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 8'h06, 1'b0}, // R8
    {1'b1, 8'h06, 1'b0, 1'b1, 1'b0, 1'b1, 8'h02, 1'b0}, // R8
    {1'b1, 8'h02, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0}, // R8 normal again
    {1'b1, 8'hE1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0}  // R2 R10
  };

  task automatic check(input string req, input logic [7:0] exp_rd, input logic exp_irq);
    n_checks++;
    if (reg_rdata_o !== exp_rd || irq_o !== exp_irq) begin
      n_fails++;
      $display("FAIL %s: rdata=%02h irq=%0b expected rdata=%02h irq=%0b",
               req, reg_rdata_o, irq_o, exp_rd, exp_irq);
    end
  endtask

  task automatic drive(input logic wr, input logic [7:0] wd, input logic c,
                       input logic e, input logic i, input logic s);
    reg_wr_i = wr; reg_wdata_i = wd; cmp_out_i = c;
    cmp_en_i = e;  cmp_inv_i = i;    stop_mode_i = s;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000 && !done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    drive(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 8'h00, 1'b0);
    rst_n = 1'b1;
    repeat (5) tick();
    check("R1 after reset", 8'h00, 1'b0);

    for (int k = 0; k < NV; k++) begin
      drive(VEC[k][21], VEC[k][20:13], VEC[k][12], VEC[k][11], VEC[k][10], VEC[k][9]);
      tick();
      check($sformatf("vector %0d", k), VEC[k][8:1], VEC[k][0]);
    end

    // R11: output high across reset release must not raise the rising flag
    drive(1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 R10 reset with output high", 8'h01, 1'b0);
    rst_n = 1'b1;
    repeat (4) tick();
    check("R11 no spurious rise", 8'h01, 1'b0);
    drive(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    tick();
    check("R11 R5 real fall after reset", 8'h02, 1'b0);

    // R11 with stop mode low, invert high while disabled through release
    drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) tick();
    check("R11 R10 disabled invert through release", 8'h01, 1'b0);

    finish_run();
  end
endmodule